// File: doc/BRIEF.md
# Converter Mode Sequencer with Configuration and Result Registers

This block sits between a bus-facing register interface and a 12-bit sampling converter. It holds the byte-wide control word and the 16-bit result word, and it decides when the converter is powered and when a conversion begins. Software selects between free-running conversions and one-shot conversions. In one-shot mode, software asks for one conversion by setting the top bit of the control word, and reads the same bit to learn whether the converter is still busy.

A conversion ends when an internal cycle counter expires (`EXT_DONE = 0`) or when the converter model raises its done strobe (`EXT_DONE = 1`). At that point the signed 12-bit sample is widened into the result word. The block exports a 2-bit gain code for the gain stage. Codes 00, 01, 10 and 11 select gains of 1, 2, 4 and 8. A reset request, such as one decoded from a bus-wide reset command, returns everything to the power-on state.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, and with no write since, the control readback is 8'h80 (free-running, gain code 00) and `conv_pwr_en` and `conv_gain` are 0.
- R2: The result readback is 16'h0000 after reset until the first conversion completes.
- R3: A completed conversion loads the result word with the 12-bit two's-complement sample in bits 11:0, and copies sample bit 11 into bits 15:12.
- R4: In free-running mode, the next conversion starts in the same cycle the previous one completes. With the internal timer, `conv_start` pulses are exactly `CONV_CYCLES` cycles apart.
- R5: In free-running mode, control bit 7 reads 1 and a written bit 7 has no effect.
- R6: Control bits 6:5 and 3:2 always read 0, whatever value is written to them.
- R7: `conv_gain` takes the gain field (control bits 1:0) only at the start of a conversion. A gain write during a conversion first appears on `conv_gain` together with the next `conv_start`.
- R8: Writing control bit 4 = 1 (one-shot) during a free-running conversion lets that conversion finish in full. Then power drops, no new conversion starts, and bit 7 reads 0.
- R9: In one-shot mode, a write with bit 7 = 1 while idle powers the converter and runs exactly one conversion. Bit 7 reads 1 from the write until completion, and afterwards the block reads bit 7 = 0 and powers down.
- R10: In one-shot mode, a write with bit 7 = 0 starts nothing, and a write with bit 7 = 1 during a conversion neither restarts nor extends it.
- R11: A one-cycle `rst_req` aborts any conversion. On the next cycle power is off, the result reads 0 and the control word reads 8'h80, and free-running conversions then resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rst_req | input | 1 | Synchronous reset request (for example a bus-wide reset command) |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 8 | Control word write value |
| cfg_rd_data | output | 8 | Control word readback with live busy bit |
| result_rd_data | output | 16 | Sign-extended result of the last conversion |
| conv_start | output | 1 | One-cycle pulse at the start of each conversion |
| conv_pwr_en | output | 1 | Converter power enable, high while converting |
| conv_gain | output | 2 | Gain code held for the running conversion |
| conv_done | input | 1 | Done strobe from the converter model (used when `EXT_DONE = 1`) |
| conv_sample | input | 12 | Two's-complement sample taken at completion |

## Verification
A sequencer stuck in the running state shows within one conversion time as `conv_pwr_en` staying high after a one-shot completion, and as bit 7 still reading 1. A sequencer that drops a pending start shows as power never rising after the request write. A timer off by one shows on the second `conv_start` pulse, because the spacing is measured against `CONV_CYCLES` exactly. A gain code latched at the wrong moment shows on the cycle after a mid-conversion write. A faulty abort shows on the cycle after `rst_req`, as a nonzero result word or a stale control word.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;

  // control word layout and reset value
  localparam int unsigned CFG_W          = 8;
  localparam int unsigned CFG_BUSY_BIT   = 7;
  localparam int unsigned CFG_SINGLE_BIT = 4;
  localparam logic [7:0]  CFG_RESET      = 8'h80;
  // storable bits of control word 6:0 (reserved bits masked off)
  localparam logic [6:0]  CFG_STORE_MASK = 7'h13;

  typedef enum logic {
    SEQ_OFF = 1'b0,
    SEQ_RUN = 1'b1
  } seq_state_e;

endpackage

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
  import adc_conv_pkg::*;
#(
  parameter int unsigned GAIN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [6:0]        wr_low_i,
  output logic [6:0]        low_o,
  output logic              single_o,
  output logic [GAIN_W-1:0] gain_o
);

  logic [6:0] low_q, low_d;
  logic       low_en;

  always_comb begin
    low_en = clr_i | wr_en_i;
    if (clr_i) low_d = CFG_RESET[6:0];
    else       low_d = wr_low_i & CFG_STORE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_q <= CFG_RESET[6:0];
    else if (low_en) low_q <= low_d;
  end

  assign low_o    = low_q;
  assign single_o = low_q[CFG_SINGLE_BIT];
  assign gain_o   = low_q[GAIN_W-1:0];

  p_resv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (low_q[6:5] == 2'b00) && (low_q[3:2] == 2'b00));

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CONV_CYCLES = 8,
  parameter bit          EXT_DONE    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic launch_i,
  input  logic ext_done_i,
  output logic done_o
);

  localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             hit;

  assign hit    = run_i && (cnt_q == CNT_LAST);
  assign done_o = run_i && (EXT_DONE ? ext_done_i : hit);

  always_comb begin
    cnt_en = clr_i | launch_i | run_i;
    if (clr_i || launch_i || done_o) cnt_d = '0;
    else                             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(CONV_CYCLES));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_conv_pkg::*;
#(
  parameter int unsigned GAIN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              single_i,
  input  logic              start_req_i,
  input  logic              done_i,
  input  logic [GAIN_W-1:0] gain_cfg_i,
  output logic              run_o,
  output logic              launch_o,
  output logic              start_o,
  output logic              busy_o,
  output logic [GAIN_W-1:0] gain_o
);

  seq_state_e        state_q, state_d;
  logic              pend_q, pend_d;
  logic              start_q;
  logic [GAIN_W-1:0] gain_q;
  logic              running;
  logic              launch;

  assign running = (state_q == SEQ_RUN);

  always_comb begin
    launch = 1'b0;
    if (!clr_i) begin
      if (!running) launch = !single_i || pend_q;
      else          launch = done_i && !single_i;
    end
  end

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    if (clr_i) begin
      state_d = SEQ_OFF;
      pend_d  = 1'b0;
    end else begin
      if (launch)                state_d = SEQ_RUN;
      else if (running && done_i) state_d = SEQ_OFF;
      if (launch)                      pend_d = 1'b0;
      else if (start_req_i && !running) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_OFF;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      start_q <= launch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gain_q <= '0;
    else if (clr_i)          gain_q <= '0;
    else if (launch)         gain_q <= gain_cfg_i;
  end

  assign run_o    = running;
  assign launch_o = launch;
  assign start_o  = start_q;
  assign busy_o   = running || pend_q;
  assign gain_o   = gain_q;

  p_cont_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    running && done_i && !single_i && !clr_i |=> running && start_q);

  p_single_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running && done_i && single_i && !clr_i |=> !running);

  p_gain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !launch && !clr_i |=> $stable(gain_q));

  p_no_pend_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !pend_q);

  p_start_powered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> running);

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned OUT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                cap_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [OUT_W-1:0]    result_o
);

  logic [OUT_W-1:0] wide;
  logic [OUT_W-1:0] res_q, res_d;
  logic             res_en;

  generate
    if (OUT_W > SAMPLE_W) begin : g_sext
      assign wide = {{(OUT_W - SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
    end else begin : g_trunc
      assign wide = sample_i[OUT_W-1:0];
    end
  endgenerate

  always_comb begin
    res_en = clr_i | cap_i;
    res_d  = clr_i ? '0 : wide;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign result_o = res_q;

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_conv_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 12,
  parameter int unsigned OUT_W       = 16,
  parameter int unsigned GAIN_W      = 2,
  parameter int unsigned CONV_CYCLES = 8,
  parameter bit          EXT_DONE    = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rst_req,
  input  logic                cfg_wr_en,
  input  logic [7:0]          cfg_wr_data,
  output logic [7:0]          cfg_rd_data,
  output logic [OUT_W-1:0]    result_rd_data,
  output logic                conv_start,
  output logic                conv_pwr_en,
  output logic [GAIN_W-1:0]   conv_gain,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_sample
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [6:0]        cfg_low;
  logic              single;
  logic [GAIN_W-1:0] gain_cfg;
  logic              start_req;
  logic              run;
  logic              launch;
  logic              busy;
  logic              done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign start_req = cfg_wr_en && cfg_wr_data[CFG_BUSY_BIT] && cfg_wr_data[CFG_SINGLE_BIT];

  adc_cfg_reg #(.GAIN_W(GAIN_W)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr_i    (rst_req),
    .wr_en_i  (cfg_wr_en),
    .wr_low_i (cfg_wr_data[6:0]),
    .low_o    (cfg_low),
    .single_o (single),
    .gain_o   (gain_cfg)
  );

  adc_conv_seq #(.GAIN_W(GAIN_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .clr_i       (rst_req),
    .single_i    (single),
    .start_req_i (start_req),
    .done_i      (done),
    .gain_cfg_i  (gain_cfg),
    .run_o       (run),
    .launch_o    (launch),
    .start_o     (conv_start),
    .busy_o      (busy),
    .gain_o      (conv_gain)
  );

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES), .EXT_DONE(EXT_DONE)) tmr_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr_i      (rst_req),
    .run_i      (run),
    .launch_i   (launch),
    .ext_done_i (conv_done),
    .done_o     (done)
  );

  adc_result_reg #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) res_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr_i    (rst_req),
    .cap_i    (done && !rst_req),
    .sample_i (conv_sample),
    .result_o (result_rd_data)
  );

  assign conv_pwr_en = run;
  assign cfg_rd_data = {(single ? busy : 1'b1), cfg_low};

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    done && !rst_req |=> result_rd_data[SAMPLE_W-1:0] == $past(conv_sample));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_req |=> (result_rd_data == '0) && (cfg_rd_data == CFG_RESET) && !conv_pwr_en);

  p_cont_busy_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !single |-> cfg_rd_data[CFG_BUSY_BIT]);

endmodule

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb_top;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_req = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_data = 8'h00;
  logic [7:0]  cfg_rd_data;
  logic [15:0] result_rd_data;
  logic        conv_start;
  logic        conv_pwr_en;
  logic [1:0]  conv_gain;
  logic        conv_done = 1'b0;
  logic [11:0] conv_sample = 12'h000;

  int checks = 0;
  int failures = 0;
  int cyc_n = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc_n++;

  adc_conv_ctrl #(.CONV_CYCLES(N), .EXT_DONE(1'b0)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rst_req        (rst_req),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_wr_data    (cfg_wr_data),
    .cfg_rd_data    (cfg_rd_data),
    .result_rd_data (result_rd_data),
    .conv_start     (conv_start),
    .conv_pwr_en    (conv_pwr_en),
    .conv_gain      (conv_gain),
    .conv_done      (conv_done),
    .conv_sample    (conv_sample)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  // returns the cycle stamp at which conv_start is seen, -1 on timeout
  task automatic wait_start(output int stamp);
    stamp = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (conv_start) begin
        stamp = cyc_n;
        break;
      end
    end
  endtask

  task automatic wait_pwr_low(output int stamp);
    stamp = -1;
    for (int i = 0; i < 200; i++) begin
      if (!conv_pwr_en) begin
        stamp = cyc_n;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    cyc(2);
    check("R1 cfg after reset", cfg_rd_data, 8'h80);
    check("R1 power after reset", conv_pwr_en, 0);
    check("R1 gain after reset", conv_gain, 0);
    check("R2 result after reset", result_rd_data, 16'h0000);
    conv_sample = 12'h7FF;
    rst_n = 1'b1;
  endtask

  task automatic t_continuous;
    int s0, s1;
    wait_start(s0);
    check("R2 result before first completion", result_rd_data, 16'h0000);
    wait_start(s1);
    check("R4 start spacing", s1 - s0, N);
    check("R3 positive sample", result_rd_data, 16'h07FF);
    check("R5 busy reads 1 in free-running", cfg_rd_data, 8'h80);
    conv_sample = 12'h800;
    wait_start(s0);
    check("R3 most negative sample", result_rd_data, 16'hF800);
    check("R4 start spacing again", s0 - s1, N);
    conv_sample = 12'h123;
    wait_start(s1);
    check("R3 mid sample", result_rd_data, 16'h0123);
  endtask

  task automatic t_reserved;
    int s;
    wr_cfg(8'h6C);
    check("R6 reserved bits read zero", cfg_rd_data, 8'h80);
    wr_cfg(8'h00);
    check("R5 written bit7 ignored", cfg_rd_data, 8'h80);
    wait_start(s);
    check("R5 conversions continue", s > 0, 1);
  endtask

  task automatic t_gain;
    int s;
    wait_start(s);
    wr_cfg(8'h03);
    check("R7 gain held mid conversion", conv_gain, 2'd0);
    check("R6 gain field readback", cfg_rd_data, 8'h83);
    wait_start(s);
    check("R7 gain applied at next start", conv_gain, 2'd3);
  endtask

  task automatic t_to_single;
    int s, p;
    conv_sample = 12'hABC;
    wait_start(s);
    cyc(2);
    wr_cfg(8'h13);
    check("R8 conversion continues after mode change", conv_pwr_en, 1);
    wait_pwr_low(p);
    check("R8 conversion ran full length", p - s, N);
    check("R8 result of finished conversion", result_rd_data, 16'hFABC);
    check("R8 busy cleared", cfg_rd_data, 8'h13);
    cyc(3 * N);
    check("R8 stays powered down", conv_pwr_en, 0);
  endtask

  task automatic t_single_shot;
    int s, p;
    conv_sample = 12'h001;
    wr_cfg(8'h93);
    check("R9 busy reads 1 after request", cfg_rd_data, 8'h93);
    wait_start(s);
    check("R9 powered during conversion", conv_pwr_en, 1);
    check("R9 busy during conversion", cfg_rd_data, 8'h93);
    wait_pwr_low(p);
    check("R9 one conversion length", p - s, N);
    check("R9 result", result_rd_data, 16'h0001);
    check("R9 busy cleared", cfg_rd_data, 8'h13);
    cyc(2 * N);
    check("R9 no further conversion", conv_pwr_en, 0);
  endtask

  task automatic t_ignored;
    int s, p;
    wr_cfg(8'h13);
    cyc(3 * N);
    check("R10 write of 0 starts nothing", conv_pwr_en, 0);
    check("R10 readback idle", cfg_rd_data, 8'h13);
    wr_cfg(8'h93);
    wait_start(s);
    cyc(2);
    wr_cfg(8'h93);
    wait_pwr_low(p);
    check("R10 restart during run ignored", p - s, N);
    cyc(2 * N);
    check("R10 no queued second conversion", conv_pwr_en, 0);
  endtask

  task automatic t_abort;
    int s;
    wr_cfg(8'h92);
    wait_start(s);
    cyc(2);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    check("R11 power off after abort", conv_pwr_en, 0);
    check("R11 result cleared", result_rd_data, 16'h0000);
    check("R11 cfg restored", cfg_rd_data, 8'h80);
    check("R11 gain cleared", conv_gain, 2'd0);
    wait_start(s);
    check("R11 free-running resumes", s > 0, 1);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_continuous();
    t_reserved();
    t_gain();
    t_to_single();
    t_single_shot();
    t_ignored();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule